// File: doc/BRIEF.md
# 3x3 Gaussian Smoothing Filter for Raster Video

This block removes pixel noise from a grayscale video stream. Pixels arrive one per qualified cycle in raster order: left to right, then top to bottom. A start-of-frame flag marks the top-left pixel of each frame. Two row-length delay lines and short per-row shift registers hold a 3x3 neighbourhood, with the newest pixel in the bottom-right corner. The filter weights that neighbourhood with a binomial kernel and divides the weighted sum by sixteen. The divide and every multiply are shifts, and the work is spread over a short adder pipeline.

Each accepted input pixel produces exactly one output pixel. The output stream is the smoothed frame in raster order, trailing the input by one row plus one pixel. Because of that lag, the tail of one frame leaves the block while the next frame enters. Pixels on the outer ring of the frame (first and last row, first and last column) are copied through unchanged. The frame width and height are build-time parameters; the row delays are plain memories that a memory compiler can map.

Top module: `gauss3x3_smoother`

## Requirements
- R1: After reset `pix_out_vld` is low, and the first IMG_W+1 pixels accepted after reset produce no output. Output starts with the pixel accepted after those.
- R2: A pixel accepted at a rising clock edge while the block is primed causes `pix_out_vld` to be high after the third rising edge that follows. The pipeline has a fixed latency, and valid and data move together.
- R3: Output pixel number j (counted from reset) belongs to accepted input pixel number j. The number of outputs equals the number of accepted inputs minus IMG_W+1.
- R4: For an interior centre pixel, the output is (sum of neighbour times weight) shifted right by 4, with the fractional bits truncated. The weights are 1 2 1 in the rows above and below and 2 4 2 in the centre row.
- R5: When the centre pixel lies in row 0, row IMG_H-1, column 0 or column IMG_W-1, its output equals its input value unchanged.
- R6: A pixel accepted with `frame_start` high is at row 0, column 0. The column advances per accepted pixel, and the row advances after IMG_W pixels.
- R7: While `pix_in_vld` is low, `pix_in` and `frame_start` are ignored. No output is produced for such cycles, and the filtered stream is unchanged by them.
- R8: The last IMG_W+1 output pixels of a frame are emitted as the first IMG_W+1 pixels of the next frame are accepted.
- R9: An all-white (255) interior region gives 255. The 12-bit weighted sum never exceeds 16*255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| pix_in_vld | input | 1 | Qualifies `pix_in` and `frame_start` |
| frame_start | input | 1 | Marks the top-left pixel of a frame |
| pix_in | input | PIX_W | Incoming grayscale intensity |
| pix_out_vld | output | 1 | Qualifies `pix_out` |
| pix_out | output | PIX_W | Smoothed grayscale intensity |

## Verification
The bench goes after the frame edges, where a wrong border test would blend pixels from the wrapped previous row into the first or last column. An off-by-one in the delay depths would show up everywhere as an impulse frame whose spread lands one pixel or one row away from where it belongs. Idle gaps carrying garbage pixels and a stray start flag check that unqualified cycles neither shift the window nor reposition the frame. The first outputs after reset and the frame-to-frame tail check the priming count and the carry-over of the lag. A wrong pipeline depth or a dropped valid would move each output's arrival cycle, which the bench compares against the accept edge of its triggering pixel.

// File: rtl/gsm_pkg.sv
package gsm_pkg;
  // Kernel side length and the normalising shift of the binomial kernel.
  localparam int unsigned KSIZE = 3;
  localparam int unsigned NORM_SHIFT = 4;
  // Extra sum bits: each 1-2-1 pass adds 2 bits.
  localparam int unsigned ROW_GROWTH = 2;
  localparam int unsigned SUM_GROWTH = 4;
endpackage

// File: rtl/gsm_row_delay.sv
// Fixed-depth delay line advanced only on enable, memory based with a
// registered read so it maps onto a single-port-per-side RAM.
module gsm_row_delay #(
  parameter int unsigned DEPTH = 640,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (en) begin
      ptr_d = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // Read old contents, then overwrite: output lags input by DEPTH enables.
  always_ff @(posedge clk) begin
    if (en) begin
      dout       <= mem[ptr_q];
      mem[ptr_q] <= din;
    end
  end
endmodule

// File: rtl/gsm_window.sv
// Builds the 3x3 neighbourhood, tracks raster position and priming.
module gsm_window #(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_sof,
  input  logic [DW-1:0] in_pix,
  output logic [DW-1:0] win_o [gsm_pkg::KSIZE][gsm_pkg::KSIZE],
  output logic          win_vld_o,
  output logic          win_border_o,
  output logic          primed_o
);
  import gsm_pkg::*;
  localparam int unsigned CW    = $clog2(IMG_W);
  localparam int unsigned RW    = $clog2(IMG_H);
  localparam int unsigned PRIME = IMG_W + 1;
  localparam int unsigned PCW   = $clog2(PRIME + 1);

  // Column 0 source of each window row: top, middle, bottom.
  logic [DW-1:0] col0 [KSIZE];
  logic [DW-1:0] mid_head;
  logic [DW-1:0] top_head;
  logic [DW-1:0] bot_head_q;

  // Middle row lags the input by one row; top row lags the middle by one
  // row. The middle delay's output is already registered, hence DEPTH-1.
  gsm_row_delay #(.DEPTH(IMG_W), .DW(DW)) u_mid_delay (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .din(in_pix), .dout(mid_head));
  gsm_row_delay #(.DEPTH(IMG_W - 1), .DW(DW)) u_top_delay (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .din(mid_head), .dout(top_head));

  always_ff @(posedge clk) begin
    if (in_vld) bot_head_q <= in_pix;
  end

  assign col0[0] = top_head;
  assign col0[1] = mid_head;
  assign col0[2] = bot_head_q;

  for (genvar r = 0; r < KSIZE; r++) begin : g_row
    logic [DW-1:0] sh_q [KSIZE-1];
    always_ff @(posedge clk) begin
      if (in_vld) begin
        sh_q[0] <= col0[r];
        for (int k = 1; k < KSIZE - 1; k++) sh_q[k] <= sh_q[k-1];
      end
    end
    assign win_o[r][0] = col0[r];
    for (genvar c = 1; c < KSIZE; c++) begin : g_col
      assign win_o[r][c] = sh_q[c-1];
    end
  end

  // Raster position of the incoming pixel and of the window centre.
  logic [CW-1:0]  col_q, col_d, cur_col, cen_col;
  logic [RW-1:0]  row_q, row_d, cur_row, cen_row;
  logic [PCW-1:0] prime_q, prime_d;
  logic           border_d, primed, wvld_d;
  logic           win_vld_q, win_border_q;

  always_comb begin
    cur_col = in_sof ? '0 : col_q;
    cur_row = in_sof ? '0 : row_q;
    col_d   = col_q;
    row_d   = row_q;
    if (in_vld) begin
      if (cur_col == CW'(IMG_W - 1)) begin
        col_d = '0;
        row_d = (cur_row == RW'(IMG_H - 1)) ? '0 : cur_row + 1'b1;
      end else begin
        col_d = cur_col + 1'b1;
        row_d = cur_row;
      end
    end
    // The centre sits one row and one pixel behind the incoming pixel.
    if (cur_col == '0) begin
      cen_col = CW'(IMG_W - 1);
      cen_row = (cur_row < RW'(2)) ? cur_row + RW'(IMG_H - 2) : cur_row - RW'(2);
    end else begin
      cen_col = cur_col - 1'b1;
      cen_row = (cur_row == '0) ? RW'(IMG_H - 1) : cur_row - 1'b1;
    end
    border_d = (cen_col == '0) || (cen_col == CW'(IMG_W - 1)) ||
               (cen_row == '0) || (cen_row == RW'(IMG_H - 1));
    primed   = (prime_q == PCW'(PRIME));
    prime_d  = (in_vld && !primed) ? prime_q + 1'b1 : prime_q;
    wvld_d   = in_vld && primed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_q     <= '0;
      prime_q   <= '0;
      win_vld_q <= 1'b0;
    end else begin
      col_q     <= col_d;
      row_q     <= row_d;
      prime_q   <= prime_d;
      win_vld_q <= wvld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) win_border_q <= border_d;
  end

  assign win_vld_o    = win_vld_q;
  assign win_border_o = win_border_q;
  assign primed_o     = primed;

  // R6: a start-flagged pixel is (0,0), so the next position is column 1, row 0.
  assert_sof_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_sof) |=> (col_q == CW'(1) && row_q == '0));
  // R6: the column wraps to 0 after the last pixel of a line.
  assert_col_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_sof && col_q == CW'(IMG_W - 1)) |=> (col_q == '0));
  // R7: unqualified cycles leave the raster position alone.
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(col_q) && $stable(row_q)));
endmodule

// File: rtl/gsm_kernel.sv
// Pipelined binomial convolution: row sums, column sum, normalise/select.
module gsm_kernel #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] win_i [gsm_pkg::KSIZE][gsm_pkg::KSIZE],
  input  logic          win_vld_i,
  input  logic          win_border_i,
  output logic [DW-1:0] pix_o,
  output logic          vld_o
);
  import gsm_pkg::*;
  localparam int unsigned RSW  = DW + ROW_GROWTH;
  localparam int unsigned SUMW = DW + SUM_GROWTH;

  // Stage 1: horizontal 1-2-1 per row.
  logic [RSW-1:0] rs_d [KSIZE];
  logic [RSW-1:0] rs_q [KSIZE];
  logic [DW-1:0]  s1_centre_q;
  logic           s1_border_q, s1_vld_q;

  for (genvar r = 0; r < KSIZE; r++) begin : g_hsum
    assign rs_d[r] = {2'b00, win_i[r][0]} + {1'b0, win_i[r][1], 1'b0} + {2'b00, win_i[r][2]};
    always_ff @(posedge clk) begin
      if (win_vld_i) rs_q[r] <= rs_d[r];
    end
  end

  always_ff @(posedge clk) begin
    if (win_vld_i) begin
      s1_centre_q <= win_i[1][1];
      s1_border_q <= win_border_i;
    end
  end

  // Stage 2: vertical 1-2-1 over the row sums.
  logic [SUMW-1:0] sum_d, s2_sum_q;
  logic [DW-1:0]   s2_centre_q;
  logic            s2_border_q, s2_vld_q;

  always_comb begin
    sum_d = {2'b00, rs_q[0]} + {1'b0, rs_q[1], 1'b0} + {2'b00, rs_q[2]};
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      s2_sum_q    <= sum_d;
      s2_centre_q <= s1_centre_q;
      s2_border_q <= s1_border_q;
    end
  end

  // Stage 3: divide by 16 or pass the border pixel through.
  logic [DW-1:0] out_d;
  logic          vld_q;

  always_comb begin
    out_d = s2_border_q ? s2_centre_q : s2_sum_q[SUMW-1:NORM_SHIFT];
  end

  always_ff @(posedge clk) begin
    if (s2_vld_q) pix_o <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      s1_vld_q <= win_vld_i;
      s2_vld_q <= s1_vld_q;
      vld_q    <= s2_vld_q;
    end
  end

  assign vld_o = vld_q;

  // R9: the weighted sum stays within 16 times the largest pixel value.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld_q |-> (s2_sum_q <= SUMW'(((1 << DW) - 1) << NORM_SHIFT)));
  // R5: a border centre leaves the pipeline unchanged two stages later.
  assert_border_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_q && s1_border_q) |=> ##1 (vld_o && pix_o == $past(s1_centre_q, 2)));
endmodule

// File: rtl/gauss3x3_smoother.sv
module gauss3x3_smoother #(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_in_vld,
  input  logic             frame_start,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_out_vld,
  output logic [PIX_W-1:0] pix_out
);
  import gsm_pkg::*;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [PIX_W-1:0] win [KSIZE][KSIZE];
  logic             win_vld, win_border, primed;

  gsm_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DW(PIX_W)) u_window (
    .clk(clk), .rst_n(rst_s), .in_vld(pix_in_vld), .in_sof(frame_start),
    .in_pix(pix_in), .win_o(win), .win_vld_o(win_vld),
    .win_border_o(win_border), .primed_o(primed));

  gsm_kernel #(.DW(PIX_W)) u_kernel (
    .clk(clk), .rst_n(rst_s), .win_i(win), .win_vld_i(win_vld),
    .win_border_i(win_border), .pix_o(pix_out), .vld_o(pix_out_vld));

  // R2: fixed latency from accept edge to output valid.
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (pix_in_vld && primed) |-> ##4 pix_out_vld);
  // R7: an unqualified cycle produces no output.
  assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !pix_in_vld |-> ##4 !pix_out_vld);
  // R1: nothing leaves the block before the window is primed.
  assert_prime_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s)
    !primed |-> ##4 !pix_out_vld);
endmodule

// File: tb/test_gauss3x3_smoother.sv
`timescale 1ns/1ps
module test_gauss3x3_smoother;
  localparam int W = 12;
  localparam int H = 6;
  localparam int DW = 8;
  localparam int FS = W * H;
  localparam int NF = 6;
  localparam int NTOT = NF * FS;
  localparam int LAG = W + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_in_vld, frame_start;
  logic [DW-1:0] pix_in;
  logic pix_out_vld;
  logic [DW-1:0] pix_out;

  always #2 clk = ~clk;

  gauss3x3_smoother #(.IMG_W(W), .IMG_H(H), .PIX_W(DW)) i_gauss3x3_smoother (
    .clk(clk), .rst_n(rst_n), .pix_in_vld(pix_in_vld), .frame_start(frame_start),
    .pix_in(pix_in), .pix_out_vld(pix_out_vld), .pix_out(pix_out));

  int img [NTOT];
  int in_edge [NTOT];
  int cyc = 0, nin = 0, nout = 0, errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit on_border(input int j);
    int p, r, c;
    p = j % FS; r = p / W; c = p % W;
    return (r == 0 || r == H - 1 || c == 0 || c == W - 1);
  endfunction

  function automatic int ref_pix(input int j);
    int f, p, r, c, acc;
    f = j / FS; p = j % FS; r = p / W; c = p % W; acc = 0;
    if (on_border(j)) return img[j];
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        acc += ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1) * img[f*FS + (r+dr)*W + (c+dc)];
    return acc >> 4;
  endfunction

  function automatic string tag_of(input int j);
    int f, p;
    f = j / FS; p = j % FS;
    if (p == 0) return "R6 origin pass-through";
    if (on_border(j)) return "R5 border pass-through";
    if (p >= FS - LAG) return "R8 frame tail";
    if (f == 1) return "R9 saturated region";
    if (f == 2) return "R7 gapped stream";
    return "R4 interior kernel";
  endfunction

  // Record the edge at which each pixel is accepted.
  always @(posedge clk) begin
    if (rst_n && pix_in_vld && nin < NTOT) begin
      in_edge[nin] = cyc;
      nin++;
    end
    cyc++;
  end

  // Compare each output against the model, in order and in time.
  always @(negedge clk) begin
    if (rst_n && pix_out_vld) begin
      if (nout + LAG < NTOT) begin
        check(cyc == in_edge[nout + LAG] + 4, "R2 latency", cyc, in_edge[nout + LAG] + 4);
        check(int'(pix_out) == ref_pix(nout), tag_of(nout), int'(pix_out), ref_pix(nout));
      end else begin
        check(1'b0, "R3 surplus output", nout, NTOT - LAG);
      end
      nout++;
    end
  end

  task automatic send_frame(input int f, input int gap_pct);
    for (int p = 0; p < FS; p++) begin
      if (f == 0 && p == LAG) begin
        @(negedge clk);
        pix_in_vld = 1'b0;
        repeat (8) @(negedge clk);
        check(nout == 0, "R1 priming", nout, 0);
      end
      if (int'($urandom % 100) < gap_pct) begin
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          pix_in_vld  = 1'b0;
          pix_in      = DW'($urandom);
          frame_start = 1'b1;
        end
      end
      @(negedge clk);
      pix_in_vld  = 1'b1;
      frame_start = (p == 0);
      pix_in      = DW'(img[f*FS + p]);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17C0DE));
    rst_n = 1'b0; pix_in_vld = 1'b0; frame_start = 1'b0; pix_in = '0;
    for (int f = 0; f < NF; f++)
      for (int p = 0; p < FS; p++) begin
        int r, c, v;
        r = p / W; c = p % W;
        case (f)
          1: v = 255;
          3: v = ((r + c) % 2) ? 255 : 0;
          4: v = (r == 2 && c == 5) ? 255 : ((r == 3 && c == 9) ? 200 : 0);
          default: v = int'($urandom % 256);
        endcase
        img[f*FS + p] = v;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pix_out_vld == 1'b0, "R1 reset state", int'(pix_out_vld), 0);
    send_frame(0, 0);
    send_frame(1, 0);
    send_frame(2, 40);
    send_frame(3, 0);
    send_frame(4, 10);
    send_frame(5, 0);
    @(negedge clk);
    pix_in_vld = 1'b0;
    repeat (12) @(negedge clk);
    check(nin == NTOT, "R7 accepted count", nin, NTOT);
    check(nout == NTOT - LAG, "R3 output count", nout, NTOT - LAG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", nout, NTOT - LAG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule